// File: doc/BRIEF.md
# Multi-Snapshot Transition Time Summer

This block is the fine-time stage of a delay-chain time-to-digital converter. The delay chain is fed by a ring oscillator that starts when a hit arrives. The oscillator's phase, and so where its edges sit along the chain, depends on the exact arrival time of the hit. A register array samples the chain once per clock and hands the block one tap vector per cycle. When the block is told that a hit has started, it takes a fixed number of consecutive tap vectors (sixteen by default).

For each tap vector, the block finds every place where two neighbouring taps disagree. This catches rising and falling edges alike. It then adds up the indices of those places. The per-vector totals are summed over the whole window. The oscillation frequency is taken as stable, so this grand total carries more timing information than any single edge position. It is presented once per hit as a fine-time value with a one-cycle valid strobe. While a window is open, further hit indications are ignored and a busy flag is shown.

Top module: `tdc_transition_summer`

## Requirements
- R1: During and right after reset, `valid_o`, `busy_o` and `sum_o` are all 0.
- R2: Within one tap vector, every index i (0 ≤ i < TAPS-1) with `taps_i[i] != taps_i[i+1]` adds the value i+1 to that vector's total. 0→1 and 1→0 steps count the same, so a vector and its bitwise complement give equal totals.
- R3: A window holds exactly NSNAP tap vectors: the one present in the cycle the hit is accepted, plus the next NSNAP-1. Tap vectors outside a window do not affect any result.
- R4: The `sum_o` of a window equals the sum of the R2 totals of its NSNAP tap vectors.
- R5: `valid_o` is high for exactly one cycle, on the clock edge NSNAP cycles after the accepting edge, that is, one pipeline stage after the register that holds the last vector's total. `sum_o` changes only together with `valid_o` and holds its value until the next result.
- R6: A hit is accepted when `hit_i` is high and `busy_o` is low. `busy_o` is then high for the NSNAP-1 cycles that follow. A `hit_i` seen while `busy_o` is high neither restarts nor shifts the window and does not change its result.
- R7: A hit offered in the first cycle in which `busy_o` is low again is accepted, so windows can run back to back. Both results are correct and appear NSNAP cycles apart.
- R8: A window of uniform tap vectors (all 0 or all 1) yields 0. A window of alternating-bit vectors yields NSNAP·TAPS·(TAPS-1)/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (one tap vector per cycle) |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 1 | Hit-start indicator; opens a window when the block is idle |
| taps_i | input | TAPS | Tap vector captured from the delay chain this cycle |
| busy_o | output | 1 | High while the rest of an open window is being collected |
| valid_o | output | 1 | One-cycle strobe marking a new `sum_o` |
| sum_o | output | bits for NSNAP·TAPS·(TAPS-1)/2 | Summed transition positions of the last window |

## Verification
The checker watches the timing skeleton on every cycle. It checks that the strobe is a single cycle long and follows the end of busy by one cycle. It checks that busy never lasts longer than NSNAP-1 cycles and only starts from an offered hit. It also checks that the result never moves without a strobe and never exceeds the arithmetic ceiling. The actual values can only be shown by the bench's scenarios: that the edge positions are weighted correctly, that both polarities count, that vectors outside the window are excluded, that mid-window hits leave the result intact, and that back-to-back windows both come out right. For these, the bench sweeps every 8-tap pattern through a 4-snapshot configuration and compares against totals it computes itself.

// File: rtl/tdc_sum_pkg.sv
package tdc_sum_pkg;

   // Largest per-vector total for a chain of the given tap count.
   function automatic int snap_max(input int taps);
      return (taps * (taps - 1)) / 2;
   endfunction

   // Bits needed to hold values 0..v.
   function automatic int bits_for(input int v);
      return (v < 1) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/tdc_edge_pos_sum.sv
module tdc_edge_pos_sum
   import tdc_sum_pkg::*;
#(
   parameter int TAPS  = 32,
   parameter int SUM_W = bits_for(snap_max(TAPS))
) (
   input  logic [TAPS-1:0]  taps_i,
   output logic [SUM_W-1:0] sum_o
);

   localparam int NEDGE = TAPS - 1;

   logic [NEDGE-1:0] edge_hit;

   // One XOR per neighbouring tap pair: both polarities are caught.
   for (genvar g = 0; g < NEDGE; g++) begin : g_edge
      assign edge_hit[g] = taps_i[g] ^ taps_i[g+1];
   end

   always_comb begin
      sum_o = '0;
      for (int i = 0; i < NEDGE; i++) begin
         if (edge_hit[i]) sum_o = sum_o + SUM_W'(i + 1);
      end
   end

endmodule

// File: rtl/tdc_window_ctrl.sv
module tdc_window_ctrl #(
   parameter int NSNAP = 16,
   parameter int CNT_W = (NSNAP < 2) ? 1 : $clog2(NSNAP)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_i,
   output logic take_o,    // current tap vector belongs to a window
   output logic first_o,   // current vector opens the window
   output logic last_o,    // current vector closes the window
   output logic busy_o
);

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NSNAP - 1);

   logic             busy_q;
   logic [CNT_W-1:0] idx_q;
   logic             accept;

   assign accept  = hit_i & ~busy_q;
   assign first_o = accept;
   assign take_o  = accept | busy_q;
   assign last_o  = busy_q & (idx_q == LAST_IDX);
   assign busy_o  = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         idx_q  <= CNT_W'(1);
      end else if (last_o) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (busy_q) begin
         idx_q  <= idx_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/tdc_sum_accum.sv
module tdc_sum_accum #(
   parameter int SNAP_W = 9,
   parameter int ACC_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic              first_i,
   input  logic              last_i,
   input  logic [SNAP_W-1:0] snap_sum_i,
   output logic [ACC_W-1:0]  sum_o,
   output logic              valid_o
);

   // Stage 1: register the per-vector total with its markers.
   logic              p_take, p_first, p_last;
   logic [SNAP_W-1:0] p_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_take  <= 1'b0;
         p_first <= 1'b0;
         p_last  <= 1'b0;
         p_sum   <= '0;
      end else begin
         p_take  <= take_i;
         p_first <= first_i;
         p_last  <= last_i;
         p_sum   <= take_i ? snap_sum_i : '0;
      end
   end

   // Stage 2: running total, published on the closing vector.
   logic [ACC_W-1:0] acc_q, acc_nxt;

   always_comb begin
      acc_nxt = p_first ? ACC_W'(p_sum) : acc_q + ACC_W'(p_sum);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         sum_o   <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (p_take) begin
            if (p_last) begin
               sum_o   <= acc_nxt;
               valid_o <= 1'b1;
               acc_q   <= '0;
            end else begin
               acc_q   <= acc_nxt;
            end
         end
      end
   end

endmodule

// File: rtl/tdc_transition_summer.sv
module tdc_transition_summer
   import tdc_sum_pkg::*;
#(
   parameter int TAPS  = 32,
   parameter int NSNAP = 16
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          hit_i,
   input  logic [TAPS-1:0]                               taps_i,
   output logic                                          busy_o,
   output logic                                          valid_o,
   output logic [bits_for(NSNAP*snap_max(TAPS))-1:0]     sum_o
);

   localparam int SNAP_W = bits_for(snap_max(TAPS));
   localparam int ACC_W  = bits_for(NSNAP * snap_max(TAPS));

   if (TAPS < 2) begin : g_bad_taps
      $error("tdc_transition_summer: TAPS must be at least 2");
   end
   if (NSNAP < 2) begin : g_bad_nsnap
      $error("tdc_transition_summer: NSNAP must be at least 2");
   end

   logic              take, first, last;
   logic [SNAP_W-1:0] snap_sum;

   tdc_window_ctrl #(.NSNAP(NSNAP)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (hit_i),
      .take_o  (take),
      .first_o (first),
      .last_o  (last),
      .busy_o  (busy_o)
   );

   tdc_edge_pos_sum #(.TAPS(TAPS), .SUM_W(SNAP_W)) u_pos (
      .taps_i (taps_i),
      .sum_o  (snap_sum)
   );

   tdc_sum_accum #(.SNAP_W(SNAP_W), .ACC_W(ACC_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_i     (take),
      .first_i    (first),
      .last_i     (last),
      .snap_sum_i (snap_sum),
      .sum_o      (sum_o),
      .valid_o    (valid_o)
   );

endmodule

// File: rtl/tdc_summer_chk.sv
module tdc_summer_chk #(
   parameter int NSNAP = 16,
   parameter int ACC_W = 13,
   parameter int LIMIT = 7936
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hit_i,
   input logic             busy_o,
   input logic             valid_o,
   input logic [ACC_W-1:0] sum_o
);

   int busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_run <= 0;
      else        busy_run <= busy_o ? busy_run + 1 : 0;
   end

   // R5
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R5
   strobe_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |=> valid_o);

   // R5
   sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> $stable(sum_o));

   // R6
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= NSNAP - 1);

   // R6
   busy_from_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(hit_i));

   // R4
   sum_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (int'(sum_o) <= LIMIT));

endmodule

bind tdc_transition_summer tdc_summer_chk #(
   .NSNAP (NSNAP),
   .ACC_W (tdc_sum_pkg::bits_for(NSNAP * tdc_sum_pkg::snap_max(TAPS))),
   .LIMIT (NSNAP * tdc_sum_pkg::snap_max(TAPS))
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .hit_i   (hit_i),
   .busy_o  (busy_o),
   .valid_o (valid_o),
   .sum_o   (sum_o)
);

// File: tb/tb_tdc_transition_summer.sv
module tb_tdc_transition_summer;

   localparam int TAPS   = 8;
   localparam int NSNAP  = 4;
   localparam int CLK_PS = 2500;
   localparam int ACC_W  = $clog2(NSNAP * TAPS * (TAPS - 1) / 2 + 1);

   typedef logic [TAPS-1:0] vec_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             hit_i = 1'b0;
   vec_t             taps_i = '0;
   logic             busy_o, valid_o;
   logic [ACC_W-1:0] sum_o;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PS/2) clk = ~clk;

   tdc_transition_summer #(.TAPS(TAPS), .NSNAP(NSNAP)) dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (hit_i),
      .taps_i  (taps_i),
      .busy_o  (busy_o),
      .valid_o (valid_o),
      .sum_o   (sum_o)
   );

   function automatic int pos_total(input vec_t v);
      int s = 0;
      for (int i = 0; i < TAPS - 1; i++) if (v[i] != v[i+1]) s += i + 1;
      return s;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Runs one window; poke raises hit_i during the busy cycles (R6).
   task automatic run_window(input vec_t s[NSNAP], input bit poke, input string tag);
      int expv = 0;
      for (int k = 0; k < NSNAP; k++) expv += pos_total(s[k]);
      @(negedge clk); hit_i = 1'b1; taps_i = s[0];
      for (int k = 1; k < NSNAP; k++) begin
         @(negedge clk);
         check(busy_o == 1'b1, {"R6 busy ", tag}, busy_o, 1);
         hit_i = poke; taps_i = s[k];
      end
      @(negedge clk);
      check(busy_o == 1'b0, {"R6 busy end ", tag}, busy_o, 0);
      check(valid_o == 1'b0, {"R5 early ", tag}, valid_o, 0);
      hit_i = 1'b0; taps_i = 8'hA5;   // outside window (R3)
      @(negedge clk);
      check(valid_o == 1'b1, {"R5 strobe ", tag}, valid_o, 1);
      check(int'(sum_o) == expv, {"R4 sum ", tag}, int'(sum_o), expv);
      taps_i = 8'h3C;
      @(negedge clk);
      check(valid_o == 1'b0, {"R5 pulse ", tag}, valid_o, 0);
      check(int'(sum_o) == expv, {"R5 hold ", tag}, int'(sum_o), expv);
   endtask

   initial begin
      vec_t s[NSNAP];
      vec_t a[NSNAP];
      vec_t b[NSNAP];
      int   ea, eb;

      // R1 reset state
      repeat (3) @(negedge clk);
      check(valid_o == 0 && busy_o == 0 && sum_o == 0, "R1 in reset", int'(sum_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(valid_o == 0 && busy_o == 0 && sum_o == 0, "R1 after reset", int'(sum_o), 0);

      // R8 uniform and alternating windows
      for (int k = 0; k < NSNAP; k++) s[k] = '0;
      run_window(s, 1'b0, "R8 zeros");
      for (int k = 0; k < NSNAP; k++) s[k] = '1;
      run_window(s, 1'b0, "R8 ones");
      for (int k = 0; k < NSNAP; k++) s[k] = (k % 2 == 0) ? 8'h55 : 8'hAA;
      run_window(s, 1'b0, "R8 alternating");
      check(int'(sum_o) == NSNAP * TAPS * (TAPS - 1) / 2, "R8 max",
            int'(sum_o), NSNAP * TAPS * (TAPS - 1) / 2);

      // R2 polarity: a rising step and a falling step at the same place
      for (int k = 0; k < NSNAP; k++) s[k] = 8'h0F;
      run_window(s, 1'b0, "R2 rise");
      check(int'(sum_o) == NSNAP * 4, "R2 rise pos", int'(sum_o), NSNAP * 4);
      for (int k = 0; k < NSNAP; k++) s[k] = 8'hF0;
      run_window(s, 1'b0, "R2 fall");
      check(int'(sum_o) == NSNAP * 4, "R2 fall pos", int'(sum_o), NSNAP * 4);

      // R2/R3/R4/R6 sweep over every tap pattern
      for (int p = 0; p < 256; p++) begin
         for (int k = 0; k < NSNAP; k++)
            s[k] = vec_t'(p * (2 * k + 1)) ^ vec_t'(k * 8'h5A);
         run_window(s, (p % 3) == 0, "sweep");
      end

      // R7 back-to-back windows
      for (int k = 0; k < NSNAP; k++) begin
         a[k] = vec_t'(8'h13 << k);
         b[k] = vec_t'(8'hC6 ^ k);
      end
      ea = 0; eb = 0;
      for (int k = 0; k < NSNAP; k++) begin
         ea += pos_total(a[k]);
         eb += pos_total(b[k]);
      end
      @(negedge clk); hit_i = 1'b1; taps_i = a[0];
      for (int k = 1; k < NSNAP; k++) begin
         @(negedge clk); hit_i = 1'b0; taps_i = a[k];
      end
      @(negedge clk);
      check(busy_o == 1'b0, "R7 idle slot", busy_o, 0);
      hit_i = 1'b1; taps_i = b[0];
      @(negedge clk);
      check(valid_o == 1'b1 && int'(sum_o) == ea, "R7 first result", int'(sum_o), ea);
      check(busy_o == 1'b1, "R7 second accepted", busy_o, 1);
      hit_i = 1'b0; taps_i = b[1];
      for (int k = 2; k < NSNAP; k++) begin
         @(negedge clk); taps_i = b[k];
      end
      @(negedge clk); taps_i = '0;
      @(negedge clk);
      check(valid_o == 1'b1 && int'(sum_o) == eb, "R7 second result", int'(sum_o), eb);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule